// File: doc/BRIEF.md
# Transmit Power Ramp Table Controller

This block holds eight programmable 8-bit transmit power codes and presents one of them to a power amplifier each clock cycle. A 3-bit selector names the highest table slot used for a transmission. When transmission begins, the output walks up through the slots from slot 0 to the selected slot, one slot per step period. It then holds the top slot. When transmission ends, it walks back down to slot 0 and then falls silent. This gives a shaped rise and fall of output power without any work from software during the packet.

In on-off keying mode the ramp is bypassed. The output follows the data bit: slot 0 is the "off" level and slot 1 is the "on" level. Table contents arrive as byte writes from an already-decoded serial port. A plain write always lands in slot 0. A write flagged as burst lands in the slot named by an internal pointer, which then advances. A sleep input wipes every slot except slot 0, which keeps its contents.

Top module: `pa_ramp_ctrl`

## Requirements
- R1: After synchronous reset, slot 0 holds 0xC6 and slots 1 to 7 hold 0x00; `pa_code` is 0x00 and `ramp_done` is 0.
- R2: A write with `wr_burst` low (`wr_valid`=1) stores `wr_data` into slot 0 only; every other slot is unchanged.
- R3: A write with `wr_burst` high stores into the slot named by a burst pointer. The pointer then advances by one and wraps from 7 to 0, so a ninth byte lands in slot 0. The pointer returns to 0 on every cycle in which `wr_burst` is low.
- R4: While no transmission is active, `pa_code` is 0x00.
- R5: When `tx_on` is sampled high in the idle state with `ook_en` low, the selector `pa_power` is captured. From the next cycle on, `pa_code` shows slot 0, 1, ... up to the captured slot. Each slot is held for STEP_CYCLES cycles (default 4). The top slot is held while `tx_on` stays high.
- R6: `ramp_done` is a one-cycle pulse. It is asserted in the first cycle in which the captured top slot is shown during the upward ramp.
- R7: When `tx_on` is sampled low during the upward ramp or the hold, the output steps down from the slot currently shown to slot 0. Each slot is held for STEP_CYCLES cycles, and the output then returns to 0x00.
- R8: With a captured selector of 0, slot 0 is shown for the whole transmission, with `ramp_done` in its first cycle. `pa_code` returns to 0x00 in the cycle after `tx_on` is sampled low.
- R9: When `tx_on` is sampled high in the idle state with `ook_en` high, `pa_code` shows slot 0 while `ook_data` is 0 and slot 1 while `ook_data` is 1. In this mode `ramp_done` stays 0, and the output is 0x00 one cycle after `tx_on` is sampled low.
- R10: While `sleep` is high, slots 1 to 7 are cleared to 0x00 and burst writes to them are dropped. Slot 0 keeps its value and still accepts writes.
- R11: A high `tx_on` during the downward ramp is ignored until the output has reached 0x00. A new ramp then starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One table byte is presented this cycle |
| wr_burst | input | 1 | Burst framing; held high for the whole burst, low resets the pointer |
| wr_data | input | 8 | Table byte |
| sleep | input | 1 | Sleep level; clears slots 1 to 7 |
| pa_power | input | 3 | Highest slot used by the ramp |
| tx_on | input | 1 | Transmission request level |
| ook_en | input | 1 | Select on-off keying mode at transmission start |
| ook_data | input | 1 | On-off keying data bit |
| pa_code | output | 8 | Power code to the amplifier |
| ramp_done | output | 1 | Pulse when the upward ramp reaches the top slot |

## Verification
On every cycle, the assertions check these properties:
- the ramp index never moves inside a step period;
- `ramp_done` is a single pulse and only marks the top slot of a ramp;
- a down ramp runs to completion once started;
- a plain write always lands in slot 0;
- the burst pointer wraps;
- sleep leaves slots 1 to 7 at zero.

Only the bench scenarios show the exact sequence of codes and its cycle alignment for different selectors, early release, and the re-start after a down ramp. The same holds for the on-off keying level choice and for the contents that survive sleep and reset, since these depend on values written earlier.

// File: rtl/pa_ramp_pkg.sv
// Package: shared constants and the sequencer state type for the power
// ramp table controller. Assumes an 8-slot table of 8-bit codes.
package pa_ramp_pkg;
    localparam int unsigned SLOTS      = 8;
    localparam int unsigned CODE_W     = 8;
    localparam int unsigned IDX_W      = $clog2(SLOTS);
    localparam logic [CODE_W-1:0] SLOT0_RST = 8'hC6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2,
        ST_OOK  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pa_tbl_store.sv
// Module: power code table with single/burst write and sleep retention.
// A write with burst low goes to slot 0. A write with burst high goes to
// the slot under the burst pointer, which then advances and wraps. Sleep
// clears every slot but slot 0. Assumes writes are already decoded into
// one-cycle byte strobes.
module pa_tbl_store #(
    parameter int unsigned N_SLOTS = 8,
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST0   = 8'hC6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic                       wr_burst,
    input  logic [W-1:0]               wr_data,
    input  logic                       sleep,
    input  logic [$clog2(N_SLOTS)-1:0] rd_idx,
    output logic [W-1:0]               rd_data
);
    localparam int unsigned IW = $clog2(N_SLOTS);
    localparam logic [IW-1:0] LAST = IW'(N_SLOTS - 1);

    logic [W-1:0]  mem [N_SLOTS];
    logic [IW-1:0] ptr;
    logic [IW-1:0] wr_idx;

    // Target slot for the current write.
    always_comb wr_idx = wr_burst ? ptr : '0;

    // Burst pointer: held at zero outside a burst, advances per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_burst) begin
            ptr <= '0;
        end else if (wr_valid) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // Table storage: reset values, writes, and sleep clearing.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(N_SLOTS); i++) begin
            if (!rst_n) begin
                mem[i] <= (i == 0) ? RST0 : '0;
            end else if (i != 0 && sleep) begin
                mem[i] <= '0;
            end else if (wr_valid && wr_idx == IW'(i)) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Read port used by the sequencer.
    always_comb rd_data = mem[rd_idx];

    // Checker helper: all retained-only slots are zero.
    logic upper_zero;
    always_comb begin
        upper_zero = 1'b1;
        for (int i = 1; i < int'(N_SLOTS); i++) begin
            if (mem[i] != '0) upper_zero = 1'b0;
        end
    end

    p_single_entry0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_burst) |=> (mem[0] == $past(wr_data)));

    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_burst && ptr == LAST) |=> (ptr == '0));

    p_sleep_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> upper_zero);
endmodule

// File: rtl/pa_step_timer.sv
// Module: free-running step period counter. It flags the last cycle of
// each STEP-cycle period and restarts at zero when cleared. Assumes STEP >= 1.
module pa_step_timer #(
    parameter int unsigned STEP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expire
);
    localparam int unsigned CW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP - 1);

    logic [CW-1:0] cnt;

    // Count cycles within the current step, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Last cycle of the step period.
    always_comb expire = (cnt == LAST);
endmodule

// File: rtl/pa_ramp_seq.sv
// Module: ramp sequencer. It chooses which table slot drives the amplifier
// and whether the output is live. It walks up to a selector captured at
// start, holds, walks down on release, or follows the data bit in on-off
// keying mode. Assumes the step timer expires once per step period when it
// is not cleared.
module pa_ramp_seq
    import pa_ramp_pkg::*;
#(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_on,
    input  logic          ook_en,
    input  logic          ook_data,
    input  logic [IW-1:0] sel,
    input  logic          expire,
    output logic          tmr_clr,
    output logic [IW-1:0] rd_idx,
    output logic          live,
    output logic          ramp_done
);
    seq_state_t    state, state_n;
    logic [IW-1:0] idx, idx_n;
    logic [IW-1:0] top_q, top_n;
    logic          done_n;

    // Next-state, index and timer-clear decisions.
    always_comb begin
        state_n = state;
        idx_n   = idx;
        top_n   = top_q;
        done_n  = 1'b0;
        tmr_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (tx_on) begin
                    if (ook_en) begin
                        state_n = ST_OOK;
                    end else begin
                        state_n = ST_UP;
                        idx_n   = '0;
                        top_n   = sel;
                        done_n  = (sel == '0);
                    end
                end
            end
            ST_UP: begin
                if (!tx_on) begin
                    state_n = (top_q == '0) ? ST_IDLE : ST_DOWN;
                    tmr_clr = 1'b1;
                end else if (expire && idx != top_q) begin
                    idx_n  = idx + 1'b1;
                    done_n = ((idx + 1'b1) == top_q);
                end
            end
            ST_DOWN: begin
                if (expire) begin
                    if (idx == '0) state_n = ST_IDLE;
                    else           idx_n   = idx - 1'b1;
                end
            end
            ST_OOK: begin
                if (!tx_on) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            top_q     <= '0;
            ramp_done <= 1'b0;
        end else begin
            state     <= state_n;
            idx       <= idx_n;
            top_q     <= top_n;
            ramp_done <= done_n;
        end
    end

    // Slot selection: data bit picks slot 0/1 in keying mode, else ramp index.
    always_comb rd_idx = (state == ST_OOK) ? IW'(ook_data) : idx;
    always_comb live   = (state != ST_IDLE);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |=> !ramp_done);

    p_done_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (state == ST_UP && idx == top_q));

    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UP && tx_on && !expire) |=> $stable(idx));

    p_down_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN && !(expire && idx == '0)) |=> (state == ST_DOWN));

    p_ook_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OOK) |-> !ramp_done);
endmodule

// File: rtl/pa_ramp_ctrl.sv
// Module: top level of the transmit power ramp table controller. It joins
// the table, the step timer and the sequencer, and gates the selected code
// to zero while idle. Assumes tx_on, ook_en and pa_power are synchronous
// to clk.
module pa_ramp_ctrl
    import pa_ramp_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_burst,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              sleep,
    input  logic [IDX_W-1:0]  pa_power,
    input  logic              tx_on,
    input  logic              ook_en,
    input  logic              ook_data,
    output logic [CODE_W-1:0] pa_code,
    output logic              ramp_done
);
    logic [IDX_W-1:0]  rd_idx;
    logic [CODE_W-1:0] rd_data;
    logic              live;
    logic              tmr_clr;
    logic              expire;

    pa_tbl_store #(.N_SLOTS(SLOTS), .W(CODE_W), .RST0(SLOT0_RST)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_burst(wr_burst),
        .wr_data(wr_data), .sleep(sleep), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    pa_step_timer #(.STEP(STEP_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .expire(expire)
    );

    pa_ramp_seq #(.IW(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .ook_en(ook_en),
        .ook_data(ook_data), .sel(pa_power), .expire(expire),
        .tmr_clr(tmr_clr), .rd_idx(rd_idx), .live(live), .ramp_done(ramp_done)
    );

    // Output gate: silent while idle.
    always_comb pa_code = live ? rd_data : '0;
endmodule

// File: tb/test_pa_ramp_ctrl.sv
module test_pa_ramp_ctrl;
    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_burst = 1'b0, sleep = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] pa_power = 3'd0;
    logic       tx_on = 1'b0, ook_en = 1'b0, ook_data = 1'b0;
    logic [7:0] pa_code;
    logic       ramp_done;

    int checks = 0;
    int fails  = 0;
    logic [7:0] tbl [8];

    // Stimulus vectors: {selector[10:8], hold cycles at top[7:0]}; the
    // expected ramp and done cycle follow from the selector and the model.
    localparam logic [10:0] VEC [6] = '{
        {3'd2, 8'd3}, {3'd7, 8'd1}, {3'd1, 8'd5},
        {3'd4, 8'd0}, {3'd0, 8'd6}, {3'd3, 8'd2}
    };

    pa_ramp_ctrl #(.STEP_CYCLES(STEP)) i_pa_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_burst(wr_burst),
        .wr_data(wr_data), .sleep(sleep), .pa_power(pa_power), .tx_on(tx_on),
        .ook_en(ook_en), .ook_data(ook_data), .pa_code(pa_code),
        .ramp_done(ramp_done)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        tbl[0] = 8'hC6;
        for (int i = 1; i < 8; i++) tbl[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_on = 1'b0; ook_en = 1'b0; wr_valid = 1'b0; wr_burst = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr_single(logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_burst = 1'b0; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        tbl[0] = d;
    endtask

    // Burst of n bytes starting at value base; the model pointer starts at 0.
    task automatic wr_burst_seq(int n, logic [7:0] base);
        int p = 0;
        @(negedge clk);
        wr_burst = 1'b1;
        for (int k = 0; k < n; k++) begin
            wr_valid = 1'b1; wr_data = base + 8'(k);
            @(negedge clk);
            if (!(sleep && p != 0)) tbl[p] = base + 8'(k);
            p = (p + 1) % 8;
        end
        wr_valid = 1'b0; wr_burst = 1'b0;
        @(negedge clk);
    endtask

    // Keying-mode read of slot 0/1 through the output.
    task automatic ook_peek(string req, logic b);
        @(negedge clk);
        ook_en = 1'b1; ook_data = b; tx_on = 1'b1;
        @(negedge clk);
        chk(req, pa_code, tbl[b]);
        tx_on = 1'b0;
        @(negedge clk);
        chk("R9 keying off returns to zero", pa_code, 8'h00);
        ook_en = 1'b0;
    endtask

    task automatic run_ramp(int sel, int hold);
        int upn = sel * STEP + 1 + hold;
        int e;
        @(negedge clk);
        pa_power = 3'(sel); tx_on = 1'b1; ook_en = 1'b0;
        for (int c = 1; c <= upn; c++) begin
            @(negedge clk);
            e = (c - 1) / STEP;
            if (e > sel) e = sel;
            chk(sel == 0 ? "R8 sel0 holds slot0" : "R5 ramp up code", pa_code, tbl[e]);
            chk("R6 ramp_done pulse", {7'd0, ramp_done}, {7'd0, (c == sel * STEP + 1)});
        end
        tx_on = 1'b0;
        if (sel == 0) begin
            @(negedge clk);
            chk("R8 sel0 immediate off", pa_code, 8'h00);
        end else begin
            for (int d = 1; d <= (sel + 1) * STEP + 1; d++) begin
                @(negedge clk);
                chk("R7 ramp down code", pa_code,
                    (d <= (sel + 1) * STEP) ? tbl[sel - (d - 1) / STEP] : 8'h00);
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset code zero", pa_code, 8'h00);
        chk("R1 reset ramp_done low", {7'd0, ramp_done}, 8'h00);
        chk("R4 idle output zero", pa_code, 8'h00);
        ook_peek("R1 slot0 reset value", 1'b0);
        ook_peek("R1 slot1 reset zero", 1'b1);

        // R3: fill all eight slots by burst.
        wr_burst_seq(8, 8'h10);
        ook_peek("R3 burst slot0", 1'b0);
        ook_peek("R3 burst slot1", 1'b1);
        // R2: plain write touches slot 0 only.
        wr_single(8'h5A);
        ook_peek("R2 single write slot0", 1'b0);
        ook_peek("R2 slot1 untouched", 1'b1);
        // R9: data bit toggling within one keyed transmission.
        @(negedge clk);
        ook_en = 1'b1; tx_on = 1'b1; ook_data = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R9 keying level", pa_code, tbl[ook_data]);
            chk("R9 no ramp_done in keying", {7'd0, ramp_done}, 8'h00);
            ook_data = ~ook_data;
        end
        tx_on = 1'b0;
        @(negedge clk);
        chk("R9 keying off", pa_code, 8'h00);
        ook_en = 1'b0;

        // Vector walk: ramps for several selectors (R5 R6 R7 R8).
        for (int v = 0; v < 6; v++) begin
            run_ramp(int'(VEC[v][10:8]), int'(VEC[v][7:0]));
            repeat (2) @(negedge clk);
            chk("R4 idle between ramps", pa_code, 8'h00);
        end

        // R7: release in the middle of the up ramp.
        @(negedge clk);
        pa_power = 3'd3; tx_on = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 mid ramp slot1", pa_code, tbl[1]);
        tx_on = 1'b0;
        @(negedge clk);
        chk("R7 early release holds slot1", pa_code, tbl[1]);
        repeat (4) @(negedge clk);
        chk("R7 early release slot0", pa_code, tbl[0]);
        repeat (4) @(negedge clk);
        chk("R7 early release idle", pa_code, 8'h00);

        // R11: request during down ramp is ignored until idle.
        @(negedge clk);
        pa_power = 3'd2; tx_on = 1'b1;
        repeat (9) @(negedge clk);
        chk("R11 at top", pa_code, tbl[2]);
        tx_on = 1'b0;
        @(negedge clk);
        tx_on = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 still descending", pa_code, tbl[1]);
        repeat (7) @(negedge clk);
        chk("R11 reaches idle", pa_code, 8'h00);
        @(negedge clk);
        chk("R11 restarts at slot0", pa_code, tbl[0]);
        tx_on = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 idle after restart", pa_code, 8'h00);

        // R3: nine-byte burst wraps into slot 0; a new burst restarts at 0.
        wr_burst_seq(9, 8'h20);
        run_ramp(7, 0);
        wr_burst_seq(1, 8'h30);
        ook_peek("R3 new burst restarts at slot0", 1'b0);
        ook_peek("R3 slot1 kept after restart", 1'b1);

        // R10: sleep clears slots 1..7, keeps slot 0, drops burst writes above 0.
        @(negedge clk);
        sleep = 1'b1;
        for (int i = 1; i < 8; i++) tbl[i] = 8'h00;
        wr_burst_seq(2, 8'h40);
        sleep = 1'b0;
        ook_peek("R10 slot0 written in sleep", 1'b0);
        ook_peek("R10 slot1 cleared", 1'b1);
        run_ramp(7, 0);

        // R1: reset restores the reset contents.
        do_reset();
        @(negedge clk);
        chk("R1 code after reset", pa_code, 8'h00);
        ook_peek("R1 slot0 after reset", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule